// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that a processor reaches over a byte-wide register bus. The count is kept in a low byte and a high byte. The clock that advances it comes from one of two places. The first is an internal tick that fires once every four system clocks. The second is an external pin, counted on its rising edges. The pin can pass through a two-flop synchronizer, or that stage can be bypassed. A selectable prescaler of 1, 2, 4 or 8 sits between the chosen source and the counter.

When the counter wraps from all-ones to zero it sets a sticky flag, and that flag drives the interrupt output. Software chooses between two access modes. In the first, the two count bytes are read and written independently. In the second, a high-byte buffer makes 16-bit reads and writes atomic.

The bus has four byte addresses: 0 is the count low byte, 1 is the count high byte, 2 is the control register and 3 is the status register. Reads are combinational from the current address. Writes and read side effects take place on the rising clock edge.

Top module: `psc_timer16`

## Requirements
- R1: After reset the count, the high-byte buffer, the control register and the flag are all zero, `irq` is 0, and every address reads 0x00.
- R2: Address 2 holds the control register, and its bits 6 and 3 always read 0. Writing 0x48 reads back 0x00, and writing 0xFF reads back 0xB7.
- R3: Control bit 0 enables counting. While it is 0 the count holds its value.
- R4: When control bit 1 is 0, the source is the internal tick, one pulse every 4 clocks. Control bit 2 has no effect on this source.
- R5: When control bit 1 is 1, rising edges on `extClkIn` are counted. Control bit 2 = 0 passes the pin through a 2-flop synchronizer before the edge detector. Control bit 2 = 1 feeds the raw pin to the edge detector.
- R6: Control bits 5:4 select how many source pulses make one increment: 00 is 1, 01 is 2, 10 is 4 and 11 is 8. A write to address 0 or 1 clears the prescaler. A new selection is applied at the next prescaler terminal count.
- R7: When control bit 7 is 0, address 0 reads and writes the live low byte, and address 1 reads and writes the live high byte.
- R8: When control bit 7 is 1:
  - A read of address 0 copies the live high byte into the buffer.
  - A read of address 1 returns the buffer.
  - A write to address 1 fills the buffer only.
  - A write to address 0 loads the count with {buffer, data} in one step.
- R9: An increment from 0xFFFF gives 0x0000. It sets status bit 0 (read at address 3) and raises `irq`.
- R10: The flag stays set until a write to address 3 with bit 0 = 0. A write with bit 0 = 1 has no effect. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R11: If a write to address 0 or 1 falls in the same cycle as an increment, the write takes effect and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (side effect in 16-bit mode) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the current address |
| extClkIn | input | 1 | External count input |
| irq | output | 1 | Overflow interrupt, equal to the sticky flag |

## Verification
A wrap can set the overflow flag in the same cycle that software writes 0 to clear it. The bench loads the count with 0xFFFF and enables the internal tick. It then issues a clearing status write on every cycle and stops as soon as `irq` is seen high. Because a write is present on every cycle, the wrap is bound to coincide with one. A flag that survives that cycle is judged correct. A second collision, a counter write landing on an increment, is provoked by writing the low byte on every cycle while counting runs. The count must then read back exactly the value written.

// File: rtl/psc_timer16_pkg.sv
package psc_timer16_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // bits that exist in the control register (6 and 3 are absent)
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hB7;

  typedef struct packed {
    logic incr;
    logic wrLo;
    logic wrHi;
    logic wide;
    logic capHi;
    logic clrFlag;
  } cnt_strobe_t;
endpackage

// File: rtl/psc_timer16_datapath.sv
module psc_timer16_datapath
  import psc_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cnt_strobe_t       strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] hiBuf,
  output logic              flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrapNow;
  assign wrapNow = strobe.incr && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.wrLo) begin
      count <= strobe.wide ? {hiBuf, wrData} : {count[CNT_W-1:BYTE_W], wrData};
    end else if (strobe.wrHi && !strobe.wide) begin
      count <= {wrData, count[BYTE_W-1:0]};
    end else if (strobe.incr) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiBuf <= '0;
    end else if (strobe.wrHi && strobe.wide) begin
      hiBuf <= wrData;
    end else if (strobe.capHi) begin
      hiBuf <= count[CNT_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (wrapNow) begin
      flag <= 1'b1;
    end else if (strobe.clrFlag) begin
      flag <= 1'b0;
    end
  end

  assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && count == CNT_MAX) |=> (flag && count == '0));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobe.clrFlag) |=> flag);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.incr && !strobe.wrLo && !strobe.wrHi) |=> $stable(count));

  assert_hi_write_buffer_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrHi && strobe.wide && !strobe.wrLo) |=> $stable(count));

  assert_wide_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLo && strobe.wide) |=> count == {$past(hiBuf), $past(wrData)});
endmodule

// File: rtl/psc_timer16_ctrl.sv
module psc_timer16_ctrl
  import psc_timer16_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              extClkIn,
  input  logic [CNT_W-1:0]  count,
  input  logic [BYTE_W-1:0] hiBuf,
  input  logic              flag,
  output cnt_strobe_t       strobe
);
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PSC_W  = 3;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [BYTE_W-1:0] ctrlReg;
  logic runEn, extSel, rawSel, wideMode;
  logic [1:0] pscSel;
  assign runEn    = ctrlReg[0];
  assign extSel   = ctrlReg[1];
  assign rawSel   = ctrlReg[2];
  assign pscSel   = ctrlReg[5:4];
  assign wideMode = ctrlReg[7];

  logic wrLo, wrHi, wrCtrl, wrStat, cntWrite;
  assign wrLo     = busWrEn && (busAddr == ADDR_LO);
  assign wrHi     = busWrEn && (busAddr == ADDR_HI);
  assign wrCtrl   = busWrEn && (busAddr == ADDR_CTRL);
  assign wrStat   = busWrEn && (busAddr == ADDR_STAT);
  assign cntWrite = wrLo || wrHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= busWrData & CTRL_MASK;
  end

  // internal tick
  logic [TICK_W-1:0] tickCnt;
  logic tickPulse;
  assign tickPulse = (tickCnt == TICK_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (tickPulse) tickCnt <= '0;
    else tickCnt <= tickCnt + 1'b1;
  end

  // external input: synchronizer, bypass mux, edge detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic edgeSrc, edgePrev, extEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= extClkIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign edgeSrc = rawSel ? extClkIn : syncQ[SYNC_STAGES-1];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgePrev <= 1'b0;
    else edgePrev <= edgeSrc;
  end
  assign extEdge = edgeSrc && !edgePrev;

  // prescaler
  logic cntPulse, pscTerm;
  logic [PSC_W-1:0] pscCnt, pscLimit;
  logic [1:0] activeSel;
  assign cntPulse = runEn && (extSel ? extEdge : tickPulse);
  assign pscLimit = (PSC_W'(1) << activeSel) - PSC_W'(1);
  assign pscTerm  = (pscCnt == pscLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt    <= '0;
      activeSel <= '0;
    end else if (cntWrite) begin
      pscCnt <= '0;
    end else if (cntPulse) begin
      if (pscTerm) begin
        pscCnt    <= '0;
        activeSel <= pscSel;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.incr    = cntPulse && pscTerm && !cntWrite;
    strobe.wrLo    = wrLo;
    strobe.wrHi    = wrHi;
    strobe.wide    = wideMode;
    strobe.capHi   = busRdEn && (busAddr == ADDR_LO) && wideMode;
    strobe.clrFlag = wrStat && !busWrData[0];
  end

  always_comb begin
    unique case (busAddr)
      ADDR_LO:   busRdData = count[BYTE_W-1:0];
      ADDR_HI:   busRdData = wideMode ? hiBuf : count[CNT_W-1:BYTE_W];
      ADDR_CTRL: busRdData = ctrlReg;
      default:   busRdData = {{(BYTE_W-1){1'b0}}, flag};
    endcase
  end

  assert_stopped_no_incr_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !strobe.incr);

  assert_write_beats_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |-> !strobe.incr);

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);

  assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdData[6] == 1'b0 && busRdData[3] == 1'b0));
endmodule

// File: rtl/psc_timer16.sv
module psc_timer16
  import psc_timer16_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       extClkIn,
  output logic       irq
);
  cnt_strobe_t       strobe;
  logic [CNT_W-1:0]  count;
  logic [BYTE_W-1:0] hiBuf;
  logic              flag;

  psc_timer16_ctrl #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .extClkIn(extClkIn), .count(count), .hiBuf(hiBuf), .flag(flag),
    .strobe(strobe)
  );

  psc_timer16_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .count(count), .hiBuf(hiBuf), .flag(flag)
  );

  assign irq = flag;
endmodule

// File: tb/sim_psc_timer16.sv
module sim_psc_timer16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       extClkIn = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  psc_timer16 u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .extClkIn(extClkIn), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mCnt = 0, mBuf = 0, mCtrl = 0, mFlag = 0;
  int mTick = 0, mPsc = 0, mSel = 0, mPrev = 0;
  int syncPipe[$] = '{0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mBuf = 0; mCtrl = 0; mFlag = 0;
      mTick = 0; mPsc = 0; mSel = 0; mPrev = 0;
      syncPipe = '{0, 0};
    end else begin
      int tickNow, synced, src, edgeNow, pulse, cntWr, incr, wide;
      int nCnt, nBuf, nFlag, limit;
      tickNow = (mTick == 3);
      mTick = (mTick + 1) % 4;
      synced = syncPipe[0];
      void'(syncPipe.pop_front());
      syncPipe.push_back(int'(extClkIn));
      src = ((mCtrl >> 2) & 1) ? int'(extClkIn) : synced;
      edgeNow = (src == 1 && mPrev == 0);
      mPrev = src;
      pulse = (mCtrl & 1) && (((mCtrl >> 1) & 1) ? edgeNow : tickNow);
      cntWr = busWrEn && (busAddr < 2);
      incr = 0;
      limit = (1 << mSel) - 1;
      if (cntWr) mPsc = 0;
      else if (pulse) begin
        if (mPsc == limit) begin
          mPsc = 0; mSel = (mCtrl >> 4) & 3; incr = 1;
        end else mPsc++;
      end
      wide = (mCtrl >> 7) & 1;
      nCnt = mCnt; nBuf = mBuf; nFlag = mFlag;
      if (busWrEn && busAddr == 0)
        nCnt = wide ? ((mBuf << 8) | busWrData) : ((mCnt & 16'hFF00) | busWrData);
      else if (busWrEn && busAddr == 1 && !wide)
        nCnt = (busWrData << 8) | (mCnt & 8'hFF);
      else if (incr)
        nCnt = (mCnt + 1) & 16'hFFFF;
      if (busWrEn && busAddr == 1 && wide) nBuf = busWrData;
      else if (busRdEn && busAddr == 0 && wide) nBuf = (mCnt >> 8) & 8'hFF;
      if (incr && mCnt == 16'hFFFF) nFlag = 1;
      else if (busWrEn && busAddr == 3 && busWrData[0] == 1'b0) nFlag = 0;
      if (busWrEn && busAddr == 2) mCtrl = busWrData & 8'hB7;
      mCnt = nCnt; mBuf = nBuf; mFlag = nFlag;
    end
  end

  function automatic int modelRead(input int a);
    case (a)
      0: return mCnt & 8'hFF;
      1: return ((mCtrl >> 7) & 1) ? mBuf : ((mCnt >> 8) & 8'hFF);
      2: return mCtrl;
      default: return mFlag;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      int exp;
      exp = modelRead(int'(busAddr));
      checks++;
      if (int'(busRdData) != exp) begin
        errors++;
        $display("FAIL %s cycle %0d addr %0d got %02h exp %02h",
                 (busAddr < 2) ? "R7/R8" : (busAddr == 2 ? "R2" : "R9"),
                 cycles, busAddr, busRdData, exp);
      end
      checks++;
      if (int'(irq) != mFlag) begin
        errors++;
        $display("FAIL R9 irq cycle %0d got %0d exp %0d", cycles, irq, mFlag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d got running exp finished", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input int exp, input string tag);
    logic [7:0] d;
    busRead(a, d);
    checks++;
    if (int'(d) != exp) begin
      errors++;
      $display("FAIL %s addr %0d got %02h exp %02h", tag, a, d, exp);
    end
  endtask

  task automatic expectModel(input logic [1:0] a, input string tag);
    logic [7:0] d;
    int exp;
    @(negedge clk);
    busAddr = a;
    #1 exp = modelRead(int'(a)); d = busRdData;
    checks++;
    if (int'(d) != exp) begin
      errors++;
      $display("FAIL %s addr %0d got %02h exp %02h", tag, a, d, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinPulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClkIn = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); extClkIn = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectRead(0, 8'h00, "R1");
    expectRead(1, 8'h00, "R1");
    expectRead(2, 8'h00, "R1");
    expectRead(3, 8'h00, "R1");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq got %0d exp 0", irq); end

    // R2 control register, bits 6 and 3 absent
    busWrite(2, 8'h48);
    expectRead(2, 8'h00, "R2");
    busWrite(2, 8'hFF);
    expectRead(2, 8'hB7, "R2");
    busWrite(2, 8'h00);

    // R7 independent byte access, R3 stopped counter holds
    busWrite(0, 8'h34);
    busWrite(1, 8'h12);
    idle(20);
    expectRead(0, 8'h34, "R7 R3");
    expectRead(1, 8'h12, "R7 R3");

    // R4 internal tick, with and without bit 2
    busWrite(2, 8'h01);
    idle(37);
    expectModel(0, "R4");
    busWrite(2, 8'h05);
    idle(41);
    expectModel(0, "R4 bit2 ignored");

    // R6 prescale selections and change at terminal count
    busWrite(2, 8'h31);
    idle(100);
    expectModel(0, "R6 1:8");
    busWrite(2, 8'h11);
    idle(30);
    expectModel(0, "R6 1:2");
    busWrite(2, 8'h21);
    idle(13);
    busWrite(0, 8'h00);
    idle(50);
    expectModel(0, "R6 1:4 prescaler clear");

    // R5 external input, synchronized then raw
    busWrite(2, 8'h03);
    pinPulses(10, 3, 3);
    idle(4);
    expectModel(0, "R5 sync");
    busWrite(2, 8'h07);
    pinPulses(12, 1, 1);
    idle(2);
    expectModel(0, "R5 raw");
    busWrite(2, 8'h13);
    pinPulses(9, 2, 4);
    idle(4);
    expectModel(0, "R5 R6 ext 1:2");

    // R8 atomic 16-bit access
    busWrite(2, 8'h80);
    busWrite(1, 8'hAB);
    expectRead(1, 8'hAB, "R8 buffer read");
    busWrite(0, 8'hCD);
    busWrite(2, 8'h00);
    expectRead(1, 8'hAB, "R8 atomic load hi");
    expectRead(0, 8'hCD, "R8 atomic load lo");
    busWrite(2, 8'h80);
    busWrite(1, 8'h55);
    busWrite(2, 8'h00);
    expectRead(1, 8'hAB, "R8 hi write buffer only");
    busWrite(2, 8'h80);
    busWrite(1, 8'h55);
    expectRead(0, 8'hCD, "R8 lo read");
    expectRead(1, 8'hAB, "R8 capture on lo read");

    // R9 wrap sets flag
    busWrite(2, 8'h00);
    busWrite(0, 8'hF0);
    busWrite(1, 8'hFF);
    busWrite(2, 8'h01);
    idle(120);
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R9 irq got %0d exp 1", irq); end
    expectRead(3, 8'h01, "R9");

    // R10 sticky flag, write 1 ignored, write 0 clears
    busWrite(3, 8'h01);
    expectRead(3, 8'h01, "R10 write one ignored");
    busWrite(3, 8'h00);
    expectRead(3, 8'h00, "R10 clear");

    // R10 set and clear in the same cycle
    busWrite(2, 8'h00);
    busWrite(0, 8'hFF);
    busWrite(1, 8'hFF);
    busWrite(2, 8'h01);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      busAddr = 2'd3; busWrData = 8'h00; busWrEn = 1'b1;
      @(posedge clk); #1;
      if (irq) break;
    end
    busWrEn = 1'b0;
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R10 set-vs-clear irq got %0d exp 1", irq); end
    expectRead(3, 8'h01, "R10 set wins");

    // R11 counter write in every cycle while counting
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      busAddr = 2'd0; busWrData = 8'h77; busWrEn = 1'b1;
    end
    @(posedge clk); #1;
    busWrEn = 1'b0;
    busWrite(2, 8'h00);
    expectRead(0, 8'h77, "R11");

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule